// File: doc/BRIEF.md
# Switching Clock Source Selector and Divider

This block produces the switching-cycle tick of a DC/DC converter controller. Its only external input is one mode pin that has three meanings. Held low, it keeps the controller on the internal high-frequency oscillator and allows automatic choice between PWM and PFM. Held high, it keeps the internal oscillator and forces PWM-only regulation. Toggling, it carries an external clock: the block moves the cycle source to that clock and inhibits PFM.

The pin is brought into the internal oscillator domain through a synchronizer. It is then classified over fixed observation windows that the internal clock counts. The selected source feeds a divide-by-22 counter. That counter emits a one-cycle pulse at each terminal count and also acts as the only place where the source may change. Every switching cycle is therefore a full count of 22 source ticks and is never shorter than 22 internal cycles.

Top module: `swclk_select`

## Requirements
- R1: After reset `cycle_start`, `ext_clk_sel`, `pwm_only` and `pfm_inhibit` are all 0 while the pin is low.
- R2: With the internal source selected, `cycle_start` pulses exactly once every 22 internal clock cycles.
- R3: `cycle_start` is high for exactly one internal clock cycle per switching cycle.
- R4: With the pin held at a static level and the internal source selected, `pwm_only` equals the pin level (1 = forced PWM, 0 = automatic) and `pfm_inhibit` is 0.
- R5: When at least 4 pin transitions fall inside one 64-cycle observation window, the pin is classified as toggling and `pfm_inhibit` goes to 1. `pfm_inhibit` stays 1 for as long as the external source is selected.
- R6: With the external source selected, `cycle_start` pulses once every 22 rising edges of the pin, so its period is 22 times the external clock period.
- R7: `ext_clk_sel` changes only in a cycle in which `cycle_start` is 1, and no two `cycle_start` pulses are fewer than 22 internal cycles apart.
- R8: Isolated pulses that give fewer than 4 transitions per window never select the external source and never raise `pfm_inhibit`.
- R9: After a full 64-cycle window with no pin transition, the block returns to the internal source at the next terminal count. From then on the period is 22 cycles again and `pwm_only` follows the static level.
- R10: `ext_clk_sel` rises only when the activity detector already reports a toggling pin, so it is still 0 a few cycles after toggling begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pin | input | 1 | Asynchronous mode / external clock pin |
| cycle_start | output | 1 | One-cycle pulse at the start of each switching cycle |
| ext_clk_sel | output | 1 | 1 while the external clock drives the divider |
| pwm_only | output | 1 | Forced PWM request (static high pin, internal source) |
| pfm_inhibit | output | 1 | PFM not allowed (external clock detected or in use) |

## Verification
The hardest case to reach is the pair of hand-overs between sources. Each one is deferred to a terminal count, and in the return direction the count that is under way when toggling stops must still finish. The bench reaches this case by running rounds with a random external half-period. In each round it enables toggling long enough to pass detection and a switch, then stops toggling at an arbitrary point in the count, then parks the pin at a random static level. A monitor watches every pulse gap and every change of the selection flag through all of these hand-overs.

// File: rtl/swclk_select_pkg.sv
package swclk_select_pkg;
    localparam int DEF_DIV       = 22;
    localparam int DEF_WIN       = 64;
    localparam int DEF_EDGE_MIN  = 4;
    localparam int DEF_SYNC      = 2;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_e;
endpackage

// File: rtl/swclk_pin_sync.sv
module swclk_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_comb chain_d[g] = chain_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_o = chain_q[STAGES-1];
endmodule

// File: rtl/swclk_activity.sv
module swclk_activity #(
    parameter int WIN      = 64,
    parameter int EDGE_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    output logic rise_o,
    output logic active_o
);
    localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int EW = $clog2(EDGE_MIN + 1);

    typedef struct packed {
        logic [WW-1:0] win;
        logic [EW-1:0] ecnt;
        logic          prev;
        logic          active;
    } act_s;

    act_s st_d, st_q;
    logic          edge_w;
    logic [EW-1:0] ecnt_nx;

    always_comb begin
        st_d    = st_q;
        edge_w  = pin_s ^ st_q.prev;
        ecnt_nx = st_q.ecnt;
        if (edge_w && (st_q.ecnt < EW'(EDGE_MIN))) ecnt_nx = st_q.ecnt + 1'b1;
        st_d.prev = pin_s;
        if (st_q.win == WW'(WIN - 1)) begin
            st_d.win  = '0;
            st_d.ecnt = '0;
            if (ecnt_nx >= EW'(EDGE_MIN)) st_d.active = 1'b1;
            else if (ecnt_nx == '0)       st_d.active = 1'b0;
        end else begin
            st_d.win  = st_q.win + 1'b1;
            st_d.ecnt = ecnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o   = pin_s & ~st_q.prev;
    assign active_o = st_q.active;
endmodule

// File: rtl/swclk_divider.sv
module swclk_divider
    import swclk_select_pkg::*;
#(
    parameter int DIV = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic ext_rise_i,
    output logic pulse_o,
    output src_e src_o
);
    localparam int CW = $clog2(DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
        src_e          src;
        logic          pulse;
    } div_s;

    div_s st_d, st_q;
    logic tick;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        tick = (st_q.src == SRC_INT) || !active_i || ext_rise_i;
        if (tick) begin
            if (st_q.cnt == CW'(DIV - 1)) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
                st_d.src   = active_i ? SRC_EXT : SRC_INT;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, src: SRC_INT, pulse: 1'b0};
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign src_o   = st_q.src;
endmodule

// File: rtl/swclk_select.sv
module swclk_select
    import swclk_select_pkg::*;
#(
    parameter int DIV      = DEF_DIV,
    parameter int WIN      = DEF_WIN,
    parameter int EDGE_MIN = DEF_EDGE_MIN,
    parameter int SYNC     = DEF_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_pin,
    output logic cycle_start,
    output logic ext_clk_sel,
    output logic pwm_only,
    output logic pfm_inhibit
);
    logic pin_s;
    logic rise;
    logic active;
    src_e src;

    swclk_pin_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(mode_pin), .pin_o(pin_s)
    );

    swclk_activity #(.WIN(WIN), .EDGE_MIN(EDGE_MIN)) u_act (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .rise_o(rise), .active_o(active)
    );

    swclk_divider #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .active_i(active), .ext_rise_i(rise),
        .pulse_o(cycle_start), .src_o(src)
    );

    assign ext_clk_sel = (src == SRC_EXT);
    assign pfm_inhibit = active | ext_clk_sel;
    assign pwm_only    = pin_s & ~active & ~ext_clk_sel;
endmodule

// File: rtl/swclk_select_chk.sv
module swclk_select_chk #(
    parameter int DIV = 22
) (
    input logic clk,
    input logic rst_n,
    input logic cycle_start,
    input logic ext_clk_sel,
    input logic pfm_inhibit,
    input logic active
);
    localparam int GW = $clog2(DIV) + 1;
    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (cycle_start) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    p_switch_at_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext_clk_sel) |-> cycle_start);

    p_min_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && seen_q) |-> (gap_q >= GW'(DIV - 1)));

    p_ext_needs_activity_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_clk_sel) |-> $past(active));

    p_inhibit_while_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clk_sel |-> pfm_inhibit);
endmodule

bind swclk_select swclk_select_chk #(.DIV(DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .ext_clk_sel(ext_clk_sel), .pfm_inhibit(pfm_inhibit), .active(active)
);

// File: tb/swclk_select_tb.sv
module swclk_select_tb;
    localparam int DIV = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_pin = 1'b0;
    logic cycle_start, ext_clk_sel, pwm_only, pfm_inhibit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic ext_en = 1'b0;
    logic static_lvl = 1'b0;
    int   half = 2;
    int   hcnt = 0;

    int  gap = 0;
    bit  seen = 0;
    int  viol = 0;
    logic prev_ext = 1'b0;

    always #10 clk = ~clk;

    swclk_select u_dut (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .cycle_start(cycle_start),
        .ext_clk_sel(ext_clk_sel), .pwm_only(pwm_only), .pfm_inhibit(pfm_inhibit)
    );

    function automatic int exp_period(bit ext, int h);
        return ext ? DIV * 2 * h : DIV;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // pin driver: external clock or static level
    initial forever begin
        @(negedge clk);
        if (ext_en) begin
            if (hcnt + 1 >= half) begin
                mode_pin <= ~mode_pin;
                hcnt = 0;
            end else hcnt++;
        end else begin
            mode_pin <= static_lvl;
            hcnt = 0;
        end
    end

    // R7 monitor: pulse spacing and switch points
    initial forever begin
        @(negedge clk);
        cyc++;
        if (rst_n) begin
            if (ext_clk_sel !== prev_ext && !cycle_start) viol++;
            if (cycle_start) begin
                if (seen && gap < DIV) viol++;
                gap = 1;
                seen = 1;
            end else gap++;
            prev_ext = ext_clk_sel;
        end
    end

    // watchdog
    initial begin
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // measure period between pulses; also checks pulse width (R3)
    task automatic measure(output int per);
        int n = 0;
        while (!cycle_start && n < 2000) begin @(negedge clk); n++; end
        @(negedge clk);
        check("R3 width", cycle_start, 0);
        per = 1;
        while (!cycle_start && per < 2000) begin @(negedge clk); per++; end
    endtask

    initial begin
        int per;
        int lvl;
        bit ext_seen;
        void'($urandom(32'h5eed_1234));

        wait_cyc(3);
        check("R1 cycle_start", cycle_start, 0);
        check("R1 ext_clk_sel", ext_clk_sel, 0);
        check("R1 pwm_only", pwm_only, 0);
        check("R1 pfm_inhibit", pfm_inhibit, 0);
        rst_n = 1'b1;

        measure(per);
        check("R2 internal period", per, exp_period(0, 0));
        check("R4 low pwm_only", pwm_only, 0);

        static_lvl = 1'b1;
        wait_cyc(10);
        check("R4 high pwm_only", pwm_only, 1);
        check("R4 high pfm_inhibit", pfm_inhibit, 0);
        measure(per);
        check("R2 period static high", per, exp_period(0, 0));

        // R8: isolated pulses, three transitions then two
        ext_seen = 0;
        static_lvl = 1'b0; wait_cyc(3);
        static_lvl = 1'b1; wait_cyc(3);
        static_lvl = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (ext_clk_sel || pfm_inhibit) ext_seen = 1;
            if (i == 100) static_lvl = 1'b1;
            if (i == 104) static_lvl = 1'b0;
        end
        check("R8 no external selection", ext_seen, 0);
        check("R8 pwm_only low", pwm_only, 0);

        for (int r = 0; r < 6; r++) begin
            half = 2 + ($urandom % 5);
            if (r == 0) half = 2;
            ext_en = 1'b1;
            wait_cyc(3);
            check("R10 not yet external", ext_clk_sel, 0);
            wait_cyc(150);
            check("R5 pfm_inhibit", pfm_inhibit, 1);
            wait_cyc(22 * 2 * half + 40);
            check("R6 ext selected", ext_clk_sel, 1);
            check("R6 pwm_only off", pwm_only, 0);
            measure(per);
            check("R6 external period", per, exp_period(1, half));
            wait_cyc($urandom % 50);
            lvl = $urandom % 2;
            static_lvl = lvl[0];
            ext_en = 1'b0;
            wait_cyc(200);
            check("R9 back to internal", ext_clk_sel, 0);
            check("R9 pfm_inhibit clear", pfm_inhibit, 0);
            check("R9 pwm_only level", pwm_only, lvl);
            measure(per);
            check("R9 internal period", per, exp_period(0, 0));
        end

        check("R7 spacing and switch points", viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule